// File: doc/BRIEF.md
# Page Write Staging Buffer

This block collects the data bytes of a single write transaction for a serial EEPROM and commits them to the storage array after the transaction ends. A protocol engine in front of it decodes the bus. It pulses `addr_load` with the 12-bit start address, pulses `data_valid` once per received data byte, and pulses `stop_evt` when the bus transaction ends. The block stores each byte in a small page buffer. The buffer entry is selected by the low address bits. The address pointer advances only within the current page.

A stop event makes the block sample the write-protect input. If protection is active, the staged bytes are discarded and the block is ready again on the next cycle. If protection is off and at least one byte arrived, the block enters a timed internal write cycle. During that cycle `busy` is high. The protocol engine uses `busy` to suppress acknowledges. Every buffer entry that received data in this transaction is written to the array through a simple one-byte-per-cycle write port.

Top module: `page_write_buf`

## Requirements
- R1: After reset, `busy` and `mem_we` are 0 and `ptr_out` is 0.
- R2: When not busy, `addr_load` copies `addr_in` into `ptr_out` on the next cycle and discards bytes staged earlier. Within one cycle, `stop_evt` takes priority over `addr_load`, and `addr_load` takes priority over `data_valid`.
- R3: An accepted data byte is stored at page entry `ptr_out[4:0]`. The low five pointer bits then increment modulo 32, and bits 11:5 stay unchanged.
- R4: When more than 32 bytes arrive in one transaction, later bytes overwrite earlier ones at the same entry. Only the last byte for each entry is committed.
- R5: A stop event while a transaction is open, with `wp`=0 and at least one byte staged, raises `busy` on the next cycle. `busy` then stays high for exactly WRITE_CYCLES cycles.
- R6: In busy cycle k (k = 0..31), `mem_we` is 1 exactly when entry k received data in this transaction. In that cycle `mem_addr` = {`ptr_out[11:5]`, k} and `mem_wdata` is the byte stored at entry k. `mem_we` is 0 at all other times.
- R7: A stop event with `wp`=1 causes no array write and leaves `busy` at 0. The staged bytes are dropped, so a later stop commits nothing.
- R8: Changing `wp` while `busy` is high has no effect on the write cycle.
- R9: While `busy` is high, `addr_load`, `data_valid` and `stop_evt` are ignored, and `ptr_out` does not change.
- R10: After a commit, `ptr_out` holds the address that follows the last byte received, wrapped within the page.
- R11: A stop event is ignored, and no write cycle starts, when no address was loaded since the last stop or when no data byte followed the load.
- R12: `data_valid` is ignored when no address has been loaded since the last stop event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Start of a write: load `addr_in` |
| addr_in | input | 12 | Start address of the write |
| data_valid | input | 1 | One received data byte on `data_in` |
| data_in | input | 8 | Data byte |
| stop_evt | input | 1 | End of the bus transaction |
| wp | input | 1 | Write protect, sampled at `stop_evt` |
| busy | output | 1 | Internal write cycle in progress |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 12 | Array write address |
| mem_wdata | output | 8 | Array write data |
| ptr_out | output | 12 | Current address pointer |

## Verification
The assertions assume that the control inputs are single-cycle, synchronous pulses. They also assume that `wp` matters only in cycles where `stop_evt` is high. The pointer-step property depends on the internal open-transaction flag, so it is checked only when neither `stop_evt` nor `addr_load` competes with `data_valid`. The stimulus drives every input on the falling edge and holds it for one full cycle. It also deliberately pulses the control inputs during busy periods and before any address load, so that the ignore rules are exercised.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
   typedef enum logic [1:0] {
      PWB_IDLE = 2'd0,
      PWB_OPEN = 2'd1,
      PWB_BUSY = 2'd2
   } pwb_state_e;
endpackage

// File: rtl/pwb_addr_ptr.sv
module pwb_addr_ptr #(
   parameter int ADDR_W = 12,
   parameter int OFS_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              step_en,
   output logic [ADDR_W-1:0] ptr
);
   localparam int PAGE_W = ADDR_W - OFS_W;

   logic [PAGE_W-1:0] page_q;
   logic [OFS_W-1:0]  ofs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= '0;
         ofs_q  <= '0;
      end else if (load_en) begin
         page_q <= load_val[ADDR_W-1:OFS_W];
         ofs_q  <= load_val[OFS_W-1:0];
      end else if (step_en) begin
         ofs_q  <= ofs_q + 1'b1;
      end
   end

   assign ptr = {page_q, ofs_q};
endmodule

// File: rtl/pwb_page_store.sv
module pwb_page_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 32,
   parameter int OFS_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_mask,
   input  logic              wr_en,
   input  logic [OFS_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [OFS_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              any_valid
);
   logic [DATA_W-1:0] slot_q [DEPTH];
   logic [DEPTH-1:0]  mask_q;

   for (genvar e = 0; e < DEPTH; e++) begin : g_slot
      logic hit;
      assign hit = wr_en && (wr_idx == OFS_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_q[e] <= '0;
            mask_q[e] <= 1'b0;
         end else if (clr_mask) begin
            mask_q[e] <= 1'b0;
         end else if (hit) begin
            slot_q[e] <= wr_data;
            mask_q[e] <= 1'b1;
         end
      end
   end

   assign rd_data   = slot_q[rd_idx];
   assign rd_valid  = mask_q[rd_idx];
   assign any_valid = |mask_q;
endmodule

// File: rtl/pwb_commit_ctrl.sv
module pwb_commit_ctrl
   import pwb_pkg::*;
#(
   parameter int DEPTH        = 32,
   parameter int OFS_W        = 5,
   parameter int WRITE_CYCLES = 40,
   parameter int CNT_W        = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             addr_load,
   input  logic             data_valid,
   input  logic             stop_evt,
   input  logic             wp,
   input  logic             any_valid,
   output logic             load_en,
   output logic             step_en,
   output logic             clr_mask,
   output logic             busy,
   output logic             txn_open,
   output logic             scan_active,
   output logic [OFS_W-1:0] scan_idx
);
   localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(WRITE_CYCLES - 1);
   localparam logic [CNT_W-1:0] SCAN_LIM  = CNT_W'(DEPTH);

   pwb_state_e        state_q, state_d;
   logic [CNT_W-1:0]  cnt_q, cnt_d;

   always_comb begin
      state_d  = state_q;
      cnt_d    = cnt_q;
      load_en  = 1'b0;
      step_en  = 1'b0;
      clr_mask = 1'b0;
      unique case (state_q)
         PWB_IDLE: begin
            if (addr_load && !stop_evt) begin
               load_en  = 1'b1;
               clr_mask = 1'b1;
               state_d  = PWB_OPEN;
            end
         end
         PWB_OPEN: begin
            if (stop_evt) begin
               if (wp || !any_valid) begin
                  clr_mask = 1'b1;
                  state_d  = PWB_IDLE;
               end else begin
                  cnt_d    = '0;
                  state_d  = PWB_BUSY;
               end
            end else if (addr_load) begin
               load_en  = 1'b1;
               clr_mask = 1'b1;
            end else if (data_valid) begin
               step_en  = 1'b1;
            end
         end
         PWB_BUSY: begin
            if (cnt_q == LAST_CNT) begin
               clr_mask = 1'b1;
               state_d  = PWB_IDLE;
            end else begin
               cnt_d    = cnt_q + 1'b1;
            end
         end
         default: state_d = PWB_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PWB_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign busy        = (state_q == PWB_BUSY);
   assign txn_open    = (state_q == PWB_OPEN);
   assign scan_active = busy && (cnt_q < SCAN_LIM);
   assign scan_idx    = cnt_q[OFS_W-1:0];
endmodule

// File: rtl/page_write_buf.sv
module page_write_buf #(
   parameter int ADDR_W       = 12,
   parameter int DATA_W       = 8,
   parameter int PAGE_BYTES   = 32,
   parameter int WRITE_CYCLES = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_load,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              data_valid,
   input  logic [DATA_W-1:0] data_in,
   input  logic              stop_evt,
   input  logic              wp,
   output logic              busy,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [ADDR_W-1:0] ptr_out
);
   localparam int OFS_W = $clog2(PAGE_BYTES);
   localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

   if (PAGE_BYTES < 2 || (1 << OFS_W) != PAGE_BYTES)
      $error("PAGE_BYTES must be a power of two of at least 2");
   if (ADDR_W <= OFS_W)
      $error("ADDR_W must exceed the page offset width");
   if (WRITE_CYCLES < PAGE_BYTES)
      $error("WRITE_CYCLES must cover one scan of the page");

   logic              load_en, step_en, clr_mask, any_valid;
   logic              txn_open, scan_active, rd_valid;
   logic [OFS_W-1:0]  scan_idx;
   logic [DATA_W-1:0] rd_data;

   pwb_commit_ctrl #(
      .DEPTH(PAGE_BYTES), .OFS_W(OFS_W),
      .WRITE_CYCLES(WRITE_CYCLES), .CNT_W(CNT_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .addr_load(addr_load), .data_valid(data_valid),
      .stop_evt(stop_evt), .wp(wp), .any_valid(any_valid),
      .load_en(load_en), .step_en(step_en), .clr_mask(clr_mask),
      .busy(busy), .txn_open(txn_open),
      .scan_active(scan_active), .scan_idx(scan_idx)
   );

   pwb_addr_ptr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .load_en(load_en), .load_val(addr_in),
      .step_en(step_en), .ptr(ptr_out)
   );

   pwb_page_store #(.DATA_W(DATA_W), .DEPTH(PAGE_BYTES), .OFS_W(OFS_W)) u_store (
      .clk(clk), .rst_n(rst_n), .clr_mask(clr_mask),
      .wr_en(step_en), .wr_idx(ptr_out[OFS_W-1:0]), .wr_data(data_in),
      .rd_idx(scan_idx), .rd_data(rd_data), .rd_valid(rd_valid),
      .any_valid(any_valid)
   );

   assign mem_we    = scan_active && rd_valid;
   assign mem_addr  = {ptr_out[ADDR_W-1:OFS_W], scan_idx};
   assign mem_wdata = rd_data;
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
   parameter int ADDR_W = 12,
   parameter int OFS_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              addr_load,
   input logic              data_valid,
   input logic              stop_evt,
   input logic              wp,
   input logic              busy,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [ADDR_W-1:0] ptr_out,
   input logic              txn_open
);
   AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy); // R6

   AST_WE_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr[ADDR_W-1:OFS_W] == ptr_out[ADDR_W-1:OFS_W])); // R6

   AST_PROTECT_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_evt && wp && !busy) |=> !busy); // R7

   AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(stop_evt) && !$past(wp))); // R5

   AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(ptr_out)); // R9

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && txn_open && data_valid && !stop_evt && !addr_load) |=>
         ((ptr_out[ADDR_W-1:OFS_W] == $past(ptr_out[ADDR_W-1:OFS_W])) &&
          (ptr_out[OFS_W-1:0] == $past(ptr_out[OFS_W-1:0]) + 1'b1))); // R3

   AST_NO_TXN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !txn_open && data_valid && !addr_load) |=> $stable(ptr_out)); // R12
endmodule

bind page_write_buf pwb_checker #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .data_valid(data_valid),
   .stop_evt(stop_evt), .wp(wp), .busy(busy), .mem_we(mem_we),
   .mem_addr(mem_addr), .ptr_out(ptr_out), .txn_open(txn_open)
);

// File: tb/tb_page_write_buf.sv
`timescale 1ns/1ps
module tb_page_write_buf;
   localparam int WC = 40;
   localparam int PB = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        addr_load = 1'b0, data_valid = 1'b0, stop_evt = 1'b0, wp = 1'b0;
   logic [11:0] addr_in = '0;
   logic [7:0]  data_in = '0;
   logic        busy, mem_we;
   logic [11:0] mem_addr, ptr_out;
   logic [7:0]  mem_wdata;

   always #2.5 clk = ~clk;

   page_write_buf #(.WRITE_CYCLES(WC)) dut (
      .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
      .data_valid(data_valid), .data_in(data_in), .stop_evt(stop_evt), .wp(wp),
      .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .ptr_out(ptr_out)
   );

   int n_checks = 0;
   int n_fail   = 0;
   int n_writes = 0;
   bit done     = 1'b0;
   logic [7:0] shadow [int];

   // behavioural reference state
   bit         m_busy = 0, m_open = 0;
   int         m_cnt = 0;
   int         m_ptr = 0;
   logic [7:0] m_buf [PB];
   bit         m_mask [PB];

   task automatic chk(string req, longint act, longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int mask_count();
      int n = 0;
      for (int i = 0; i < PB; i++) n += m_mask[i];
      return n;
   endfunction

   task automatic model_update();
      if (m_busy) begin
         if (m_cnt == WC - 1) begin
            m_busy = 0; m_open = 0;
            for (int i = 0; i < PB; i++) m_mask[i] = 0;
         end else m_cnt++;
      end else if (stop_evt) begin
         if (m_open) begin
            if (wp || mask_count() == 0) begin
               m_open = 0;
               for (int i = 0; i < PB; i++) m_mask[i] = 0;
            end else begin
               m_busy = 1; m_cnt = 0;
            end
         end
      end else if (addr_load) begin
         m_ptr = addr_in; m_open = 1;
         for (int i = 0; i < PB; i++) m_mask[i] = 0;
      end else if (data_valid && m_open) begin
         m_buf[m_ptr % PB] = data_in;
         m_mask[m_ptr % PB] = 1;
         m_ptr = (m_ptr / PB) * PB + ((m_ptr % PB) + 1) % PB;
      end
   endtask

   task automatic compare();
      bit exp_we;
      exp_we = m_busy && (m_cnt < PB) && m_mask[m_cnt % PB];
      chk("R5 busy", busy, m_busy);
      chk("R3 ptr_out", ptr_out, m_ptr);
      chk("R6 mem_we", mem_we, exp_we);
      if (exp_we && mem_we) begin
         chk("R6 mem_addr", mem_addr, (m_ptr / PB) * PB + m_cnt);
         chk("R6 mem_wdata", mem_wdata, m_buf[m_cnt]);
      end
      if (mem_we) begin
         shadow[int'(mem_addr)] = mem_wdata;
         n_writes++;
      end
   endtask

   task automatic step();
      @(posedge clk);
      model_update();
      @(negedge clk);
      compare();
   endtask

   task automatic load(input logic [11:0] a);
      addr_load = 1; addr_in = a; step(); addr_load = 0;
   endtask

   task automatic send(input logic [7:0] d);
      data_valid = 1; data_in = d; step(); data_valid = 0;
   endtask

   task automatic stop(input logic w);
      stop_evt = 1; wp = w; step(); stop_evt = 0;
   endtask

   task automatic drain();
      while (m_busy) step();
      step();
   endtask

   function automatic logic [7:0] rd_shadow(int a);
      return shadow.exists(a) ? shadow[a] : 8'h00;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R5 watchdog: actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int busy_len;
      for (int i = 0; i < PB; i++) begin m_buf[i] = '0; m_mask[i] = 0; end
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 busy", busy, 0);
      chk("R1 mem_we", mem_we, 0);
      chk("R1 ptr_out", ptr_out, 0);
      rst_n = 1;
      @(negedge clk);

      // R12 data before any load, R11 stop without load
      send(8'h11);
      stop(0);
      chk("R11 no cycle", busy, 0);

      // single byte write; R2 load, R10 pointer after commit
      load(12'h123);
      chk("R2 ptr loaded", ptr_out, 12'h123);
      send(8'hA5);
      n_writes = 0;
      stop(0);
      busy_len = 0;
      while (busy) begin busy_len++; step(); end
      chk("R5 busy length", busy_len, WC);
      chk("R6 single write", n_writes, 1);
      chk("R6 stored byte", rd_shadow(12'h123), 8'hA5);
      chk("R10 ptr after", ptr_out, 12'h124);

      // page wrap at boundary, wp toggled during busy (R8)
      load(12'h3FD);
      for (int i = 0; i < 5; i++) send(8'h30 + 8'(i));
      stop(0);
      wp = 1; step(); step(); wp = 0;
      drain();
      chk("R3 wrap low", rd_shadow(12'h3E0), 8'h33);
      chk("R8 wrap high", rd_shadow(12'h3FF), 8'h32);
      chk("R3 no next page", rd_shadow(12'h400), 8'h00);
      chk("R10 wrapped ptr", ptr_out, 12'h3E2);

      // more than a page: overwrite (R4)
      load(12'h040);
      for (int i = 0; i < 34; i++) send(8'h80 + 8'(i));
      n_writes = 0;
      stop(0);
      // R9: control inputs during busy
      addr_load = 1; addr_in = 12'h777; data_valid = 1; data_in = 8'hEE; stop_evt = 1;
      step(); step();
      addr_load = 0; data_valid = 0; stop_evt = 0;
      chk("R9 ptr held", ptr_out, 12'h042);
      drain();
      chk("R4 entry0", rd_shadow(12'h040), 8'hA0);
      chk("R4 entry1", rd_shadow(12'h041), 8'hA1);
      chk("R4 entry2", rd_shadow(12'h042), 8'h82);
      chk("R4 count", n_writes, 32);

      // write protect (R7)
      load(12'h500);
      send(8'h5A);
      stop(1);
      chk("R7 no busy", busy, 0);
      stop(0);
      chk("R7 dropped", busy, 0);
      repeat (3) step();
      chk("R7 not written", rd_shadow(12'h500), 8'h00);

      // R11 load without data; R2 priority stop over load
      load(12'h600);
      stop(0);
      chk("R11 empty stop", busy, 0);
      load(12'h610);
      send(8'h61);
      stop_evt = 1; addr_load = 1; addr_in = 12'h7F0; step();
      stop_evt = 0; addr_load = 0;
      chk("R2 stop wins", busy, 1);
      drain();
      chk("R2 committed", rd_shadow(12'h610), 8'h61);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule